// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a memory-mapped event timer. One free-running 64-bit main counter is shared by a parameterised set of comparator channels. Each channel compares its comparator register against the counter and raises an interrupt on a match. Each channel can run one-shot or periodic, signal by edge or by level, and compare on all 64 bits or on the low 32 bits only. Software reaches every register through a simple 32-bit register bus. Writes are strobed. Reads are combinational from the address.

A periodic channel holds a separate period register. A self-clearing value-set flag decides whether a comparator write lands in the compare value or in the period. The first write after software sets the flag loads the compare value. Later writes load only the period. A legacy-replacement switch moves channels 0 and 1 onto two dedicated interrupt outputs. A channel that has message delivery enabled emits a one-cycle write request carrying its route data and route address, and raises no wire.

Top module: `evt_timer_top`

## Requirements
- R1: The main counter increments by one per clock only while general-config (0x010) bit 0 is set. When the bit is clear, the counter holds its value.
- R2: The main counter is read and written as a low half at 0xF0 and a high half at 0xF4. A write loads only the addressed half, and writing zero to both halves clears the counter.
- R3: Offset 0x000 reads channels-minus-one in bits [4:0] and the legacy-capable flag in bit 8. Offset 0x004 reads the tick length in femtoseconds. Writes to both are ignored, and unmapped offsets read zero.
- R4: Channel n's registers start at 0x100 + 32·n. The configuration register is at +0x00, with interrupt enable in bit 0 and level select in bit 4. In one-shot edge mode, the channel's interrupt line is high for exactly one cycle, in the cycle after the one in which the counter equals the comparator. With interrupt enable clear, the channel never raises its line or its status bit.
- R5: Periodic mode is configuration bit 1 and value-set is bit 2. While both are set, a write to the low comparator word (+0x08) loads the compare value and clears value-set. With value-set clear, a comparator write loads only the period and leaves the compare value unchanged.
- R6: On each periodic match, the comparator adds the period to itself, so pulses repeat exactly one period apart.
- R7: In level mode, a match sets the channel's bit n in the status register (0x020). The line stays high until software writes 1 to that bit. Writing 1 to other bits leaves it set.
- R8: With configuration bit 3 set, the channel matches on the low 32 counter bits only, and the periodic addition wraps at 32 bits without carrying into the high word (+0x0C).
- R9: With general-config bit 1 set, channel 0 drives the legacy timer output and channel 1 drives the legacy RTC output, and their normal interrupt lines stay low.
- R10: The route data word is at +0x10 and the route address at +0x14. With configuration bit 5 set, a match issues a one-cycle message carrying that data and address and raises no line. When channels collide, the lowest channel wins.
- R11: Configuration bits 8 and 9 read the per-channel periodic-capable and message-capable flags. Periodic or message enable cannot be set on a channel that lacks the matching capability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Register byte address |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqLine | output | NUM_CH | Per-channel interrupt lines |
| legacyTimerIrq | output | 1 | Channel 0 interrupt in legacy-replacement mode |
| legacyRtcIrq | output | 1 | Channel 1 interrupt in legacy-replacement mode |
| msgValid | output | 1 | One-cycle message write request |
| msgAddr | output | 32 | Message target address |
| msgData | output | 32 | Message payload |

## Verification
The assertions assume that the bus carries at most one write per cycle. They also assume that software never writes the comparator of a channel in the same cycle as that channel's match. The periodic-step and status-hold properties exclude any cycle with such a write. The stimulus drives each write for exactly one clock from the falling edge. It configures channels while the counter is stopped and starts the counter last, so every match time follows from the programmed compare values alone.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int SEL_W  = 6;

  localparam logic [ADDR_W-1:0] OFS_CAPS    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_PERIOD  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_GCFG    = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_ISTAT   = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 12'h0F0;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 12'h0F4;
  localparam logic [ADDR_W-1:0] OFS_CH_BASE = 12'h100;

  localparam logic [4:0] CH_CFG     = 5'h00;
  localparam logic [4:0] CH_CMP_LO  = 5'h08;
  localparam logic [4:0] CH_CMP_HI  = 5'h0C;
  localparam logic [4:0] CH_RT_DATA = 5'h10;
  localparam logic [4:0] CH_RT_ADDR = 5'h14;

  // Strobes from control to datapath; at most one write per cycle.
  typedef struct packed {
    logic              cntLoWr;
    logic              cntHiWr;
    logic              cmpLoWr;
    logic              cmpHiWr;
    logic [SEL_W-1:0]  chSel;
    logic [DATA_W-1:0] wrData;
  } dpStrobe_t;
endpackage

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 runEn,
  input  logic [NUM_CH-1:0]    periodic,
  input  logic [NUM_CH-1:0]    mode32,
  input  logic [NUM_CH-1:0]    valueSet,
  output logic [63:0]          cnt,
  output logic [NUM_CH*64-1:0] cmpFlat,
  output logic [NUM_CH*64-1:0] perFlat,
  output logic [NUM_CH-1:0]    match
);
  // Main counter: a bus write wins over the increment.
  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.cntLoWr) cnt[31:0]  <= strobe.wrData;
    else if (strobe.cntHiWr) cnt[63:32] <= strobe.wrData;
    else if (runEn)          cnt <= cnt + 64'd1;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    logic [63:0] cmpR;
    logic [63:0] perR;
    logic        selMe;
    logic        toPeriod;

    assign selMe    = (strobe.chSel == SEL_W'(i));
    assign toPeriod = periodic[i] && !valueSet[i];
    assign match[i] = runEn && (mode32[i] ? (cnt[31:0] == cmpR[31:0]) : (cnt == cmpR));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpR <= '0;
        perR <= '0;
      end else if (strobe.cmpLoWr && selMe) begin
        if (toPeriod) perR[31:0] <= strobe.wrData;
        else          cmpR[31:0] <= strobe.wrData;
      end else if (strobe.cmpHiWr && selMe) begin
        if (toPeriod) perR[63:32] <= strobe.wrData;
        else          cmpR[63:32] <= strobe.wrData;
      end else if (match[i] && periodic[i]) begin
        if (mode32[i]) cmpR[31:0] <= cmpR[31:0] + perR[31:0];
        else           cmpR <= cmpR + perR;
      end
    end

    assign cmpFlat[i*64 +: 64] = cmpR;
    assign perFlat[i*64 +: 64] = perR;
  end
endmodule

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CH     = 3,
  parameter logic [31:0] PERIOD_FS  = 32'd69841279,
  parameter bit          LEGACY_CAP = 1'b1,
  parameter logic [31:0] PER_CAP    = 32'h3,
  parameter logic [31:0] MSG_CAP    = 32'h6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [63:0]          cnt,
  input  logic [NUM_CH*64-1:0] cmpFlat,
  input  logic [NUM_CH-1:0]    match,
  output dpStrobe_t            strobe,
  output logic                 runEn,
  output logic [NUM_CH-1:0]    periodic,
  output logic [NUM_CH-1:0]    mode32,
  output logic [NUM_CH-1:0]    valueSet,
  output logic [NUM_CH-1:0]    status,
  output logic [NUM_CH-1:0]    irqLine,
  output logic                 legacyTimerIrq,
  output logic                 legacyRtcIrq,
  output logic                 msgValid,
  output logic [DATA_W-1:0]    msgAddr,
  output logic [DATA_W-1:0]    msgData
);
  localparam bit LEG_OK = LEGACY_CAP && (NUM_CH >= 2);
  localparam logic [31:0] CAPS_WORD = (32'(NUM_CH - 1) & 32'h1F) | (LEG_OK ? 32'h100 : 32'h0);

  logic [ADDR_W-1:0] chOff;
  logic [6:0]        chIdx;
  logic [4:0]        regOff;
  logic              inCh;
  logic              gcfgWr, istatWr, cfgWr, rtDataWr, rtAddrWr;
  logic              legacyOn;
  logic [NUM_CH-1:0] chIrq, msgFire;
  logic [31:0]       cfgWord [NUM_CH];
  logic [31:0]       rtDataA [NUM_CH];
  logic [31:0]       rtAddrA [NUM_CH];

  assign chOff  = busAddr - OFS_CH_BASE;
  assign chIdx  = chOff[11:5];
  assign regOff = chOff[4:0];
  assign inCh   = (busAddr >= OFS_CH_BASE) && (chIdx < 7'(NUM_CH));

  assign gcfgWr   = busWrEn && (busAddr == OFS_GCFG);
  assign istatWr  = busWrEn && (busAddr == OFS_ISTAT);
  assign cfgWr    = busWrEn && inCh && (regOff == CH_CFG);
  assign rtDataWr = busWrEn && inCh && (regOff == CH_RT_DATA);
  assign rtAddrWr = busWrEn && inCh && (regOff == CH_RT_ADDR);

  always_comb begin
    strobe.cntLoWr = busWrEn && (busAddr == OFS_CNT_LO);
    strobe.cntHiWr = busWrEn && (busAddr == OFS_CNT_HI);
    strobe.cmpLoWr = busWrEn && inCh && (regOff == CH_CMP_LO);
    strobe.cmpHiWr = busWrEn && inCh && (regOff == CH_CMP_HI);
    strobe.chSel   = chIdx[SEL_W-1:0];
    strobe.wrData  = busWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      legacyOn <= 1'b0;
    end else if (gcfgWr) begin
      runEn    <= busWrData[0];
      legacyOn <= busWrData[1] && LEG_OK;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    localparam bit IS_LEG = LEG_OK && (i < 2);
    logic ienR, perR, vsetR, m32R, lvlR, msgEnR, statusR, pulseR, selMe, effMsg;
    logic [31:0] rtDataR, rtAddrR;

    assign selMe  = (chIdx == 7'(i));
    assign effMsg = msgEnR && !(IS_LEG && legacyOn);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        {ienR, perR, vsetR, m32R, lvlR, msgEnR} <= '0;
        rtDataR <= '0;
        rtAddrR <= '0;
      end else begin
        if (cfgWr && selMe) begin
          ienR   <= busWrData[0];
          perR   <= busWrData[1] && PER_CAP[i];
          vsetR  <= busWrData[2];
          m32R   <= busWrData[3];
          lvlR   <= busWrData[4];
          msgEnR <= busWrData[5] && MSG_CAP[i];
        end else if (strobe.cmpLoWr && selMe && perR) begin
          vsetR <= 1'b0;
        end
        if (rtDataWr && selMe) rtDataR <= busWrData;
        if (rtAddrWr && selMe) rtAddrR <= busWrData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusR <= 1'b0;
        pulseR  <= 1'b0;
      end else begin
        if (match[i] && ienR && lvlR && !effMsg) statusR <= 1'b1;
        else if (istatWr && busWrData[i])        statusR <= 1'b0;
        pulseR <= match[i] && ienR && !lvlR && !effMsg;
      end
    end

    assign chIrq[i]    = pulseR || (statusR && lvlR);
    assign irqLine[i]  = chIrq[i] && !(IS_LEG && legacyOn);
    assign msgFire[i]  = match[i] && ienR && effMsg;
    assign status[i]   = statusR;
    assign periodic[i] = perR;
    assign mode32[i]   = m32R;
    assign valueSet[i] = vsetR;
    assign rtDataA[i]  = rtDataR;
    assign rtAddrA[i]  = rtAddrR;
    assign cfgWord[i]  = {22'b0, MSG_CAP[i], PER_CAP[i], 2'b0, msgEnR, lvlR, m32R, vsetR, perR, ienR};
  end

  if (LEG_OK) begin : gLeg
    assign legacyTimerIrq = legacyOn && chIrq[0];
    assign legacyRtcIrq   = legacyOn && chIrq[1];
  end else begin : gNoLeg
    assign legacyTimerIrq = 1'b0;
    assign legacyRtcIrq   = 1'b0;
  end

  // Message issue: the descending loop lets the lowest firing channel win.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgAddr  <= '0;
      msgData  <= '0;
    end else begin
      msgValid <= |msgFire;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
        if (msgFire[i]) begin
          msgData <= rtDataA[i];
          msgAddr <= rtAddrA[i];
        end
      end
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_CAPS:   busRdData = CAPS_WORD;
      OFS_PERIOD: busRdData = PERIOD_FS;
      OFS_GCFG:   busRdData = {30'b0, legacyOn, runEn};
      OFS_ISTAT:  busRdData = 32'(status);
      OFS_CNT_LO: busRdData = cnt[31:0];
      OFS_CNT_HI: busRdData = cnt[63:32];
      default:    busRdData = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (inCh && (chIdx == 7'(i))) begin
        case (regOff)
          CH_CFG:     busRdData = cfgWord[i];
          CH_CMP_LO:  busRdData = cmpFlat[i*64 +: 32];
          CH_CMP_HI:  busRdData = cmpFlat[i*64+32 +: 32];
          CH_RT_DATA: busRdData = rtDataA[i];
          CH_RT_ADDR: busRdData = rtAddrA[i];
          default:    busRdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CH     = 3,
  parameter logic [31:0] PERIOD_FS  = 32'd69841279,
  parameter bit          LEGACY_CAP = 1'b1,
  parameter logic [31:0] PER_CAP    = 32'h3,
  parameter logic [31:0] MSG_CAP    = 32'h6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [NUM_CH-1:0] irqLine,
  output logic              legacyTimerIrq,
  output logic              legacyRtcIrq,
  output logic              msgValid,
  output logic [31:0]       msgAddr,
  output logic [31:0]       msgData
);
  dpStrobe_t            strobe;
  logic                 runEn;
  logic [NUM_CH-1:0]    periodic, mode32, valueSet, status, match;
  logic [63:0]          cnt;
  logic [NUM_CH*64-1:0] cmpFlat, perFlat;

  evt_timer_ctrl #(
    .NUM_CH(NUM_CH), .PERIOD_FS(PERIOD_FS), .LEGACY_CAP(LEGACY_CAP),
    .PER_CAP(PER_CAP), .MSG_CAP(MSG_CAP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .cnt(cnt), .cmpFlat(cmpFlat),
    .match(match), .strobe(strobe), .runEn(runEn), .periodic(periodic),
    .mode32(mode32), .valueSet(valueSet), .status(status), .irqLine(irqLine),
    .legacyTimerIrq(legacyTimerIrq), .legacyRtcIrq(legacyRtcIrq),
    .msgValid(msgValid), .msgAddr(msgAddr), .msgData(msgData)
  );

  evt_timer_dp #(.NUM_CH(NUM_CH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .runEn(runEn), .periodic(periodic),
    .mode32(mode32), .valueSet(valueSet), .cnt(cnt), .cmpFlat(cmpFlat),
    .perFlat(perFlat), .match(match)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [11:0]          busAddr,
  input logic                 busWrEn,
  input logic [31:0]          busWrData,
  input logic [63:0]          cnt,
  input logic                 runEn,
  input dpStrobe_t            strobe,
  input logic [NUM_CH-1:0]    match,
  input logic [NUM_CH-1:0]    periodic,
  input logic [NUM_CH-1:0]    mode32,
  input logic [NUM_CH-1:0]    valueSet,
  input logic [NUM_CH-1:0]    status,
  input logic [NUM_CH*64-1:0] cmpFlat,
  input logic [NUM_CH*64-1:0] perFlat
);
  logic istatWr, cntWr;
  assign istatWr = busWrEn && (busAddr == OFS_ISTAT);
  assign cntWr   = strobe.cntLoWr || strobe.cntHiWr;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !cntWr) |=> (cnt == $past(cnt) + 64'd1)); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntWr) |=> $stable(cnt)); // R1

  for (genvar i = 0; i < NUM_CH; i++) begin : gChk
    logic cmpWrMe;
    assign cmpWrMe = (strobe.cmpLoWr || strobe.cmpHiWr) && (strobe.chSel == SEL_W'(i));

    AST_VSET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.cmpLoWr && strobe.chSel == SEL_W'(i) && periodic[i] && valueSet[i]) |=> !valueSet[i]); // R5
    AST_PERIOD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.cmpLoWr && strobe.chSel == SEL_W'(i) && periodic[i] && !valueSet[i])
      |=> (cmpFlat[i*64 +: 32] == $past(cmpFlat[i*64 +: 32]))); // R5
    AST_PERIODIC_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (match[i] && periodic[i] && !mode32[i] && !cmpWrMe)
      |=> (cmpFlat[i*64 +: 64] == $past(cmpFlat[i*64 +: 64]) + $past(perFlat[i*64 +: 64]))); // R6
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (status[i] && !(istatWr && busWrData[i])) |=> status[i]); // R7
  end
endmodule

bind evt_timer_top evt_timer_chk #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
  .cnt(cnt), .runEn(runEn), .strobe(strobe), .match(match), .periodic(periodic),
  .mode32(mode32), .valueSet(valueSet), .status(status), .cmpFlat(cmpFlat), .perFlat(perFlat)
);

// File: tb/evt_timer_top_test.sv
`timescale 1ns/1ps
module evt_timer_top_test;
  localparam int          NCH    = 3;
  localparam logic [31:0] PER_FS = 32'd69841279;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NCH-1:0] irqLine;
  logic        legacyTimerIrq, legacyRtcIrq, msgValid;
  logic [31:0] msgAddr, msgData;

  evt_timer_top #(.NUM_CH(NCH), .PERIOD_FS(PER_FS), .LEGACY_CAP(1'b1),
                  .PER_CAP(32'h3), .MSG_CAP(32'h6)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqLine(irqLine),
    .legacyTimerIrq(legacyTimerIrq), .legacyRtcIrq(legacyRtcIrq),
    .msgValid(msgValid), .msgAddr(msgAddr), .msgData(msgData)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int hitCnt [6];
  int firstHit [6];
  int seq [8];
  int seqN;
  bit lineSeen;
  logic [31:0] capData, capAddr, rv;

  function automatic logic [11:0] chA(input int ch, input int off);
    return 12'(32'h100 + ch * 32 + off);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic sigOf(input int s);
    case (s)
      0, 1, 2: return irqLine[s];
      3:       return legacyTimerIrq;
      4:       return legacyRtcIrq;
      default: return msgValid;
    endcase
  endfunction

  // Watch all outputs for `limit` falling edges after the run write.
  task automatic watch(input int limit, input int sel);
    for (int s = 0; s < 6; s++) begin hitCnt[s] = 0; firstHit[s] = -1; end
    seqN = 0; lineSeen = 1'b0;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      for (int s = 0; s < 6; s++) begin
        if (sigOf(s)) begin
          if (hitCnt[s] == 0) firstHit[s] = n;
          if (s == 5 && hitCnt[s] == 0) begin capData = msgData; capAddr = msgAddr; end
          hitCnt[s]++;
        end
      end
      if (|irqLine) lineSeen = 1'b1;
      if (sigOf(sel) && seqN < 8) begin seq[seqN] = n; seqN++; end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int d;
    void'($urandom(32'd4711));
    doReset();

    // R3 reset and identity registers
    rd(12'h000, rv); check("R3 caps", rv, 32'(NCH - 1) | 32'h100);
    rd(12'h004, rv); check("R3 period", rv, PER_FS);
    rd(12'h010, rv); check("R1 gcfg reset", rv, 0);
    rd(12'h0F0, rv); check("R2 cnt reset", rv, 0);
    rd(chA(0, 0), rv); check("R11 ch0 cfg reset", rv, 32'h100);
    rd(chA(1, 0), rv); check("R11 ch1 cfg reset", rv, 32'h300);
    rd(chA(2, 0), rv); check("R11 ch2 cfg reset", rv, 32'h200);
    rd(12'h0C0, rv); check("R3 unmapped", rv, 0);
    rd(chA(NCH, 0), rv); check("R3 beyond channels", rv, 0);
    wr(12'h000, 32'hFFFF_FFFF); wr(12'h004, 32'h0);
    rd(12'h000, rv); check("R3 caps write ignored", rv, 32'(NCH - 1) | 32'h100);
    rd(12'h004, rv); check("R3 period write ignored", rv, PER_FS);

    // R11 capability gating
    wr(chA(2, 0), 32'h3F); rd(chA(2, 0), rv); check("R11 ch2 no periodic", rv, 32'h23D);
    wr(chA(0, 0), 32'h3F); rd(chA(0, 0), rv); check("R11 ch0 no message", rv, 32'h11F);
    doReset();

    // R1 R2 counter
    wr(12'h0F0, 32'h1234_5678); wr(12'h0F4, 32'hA);
    rd(12'h0F0, rv); check("R2 cnt lo", rv, 32'h1234_5678);
    rd(12'h0F4, rv); check("R2 cnt hi", rv, 32'hA);
    wr(12'h010, 32'h1);
    repeat (10) @(negedge clk);
    wr(12'h010, 32'h0);
    rd(12'h0F0, rv); check("R1 counted", rv, 32'h1234_5684);
    repeat (5) @(negedge clk);
    rd(12'h0F0, rv); check("R1 frozen", rv, 32'h1234_5684);
    rd(12'h0F4, rv); check("R1 hi kept", rv, 32'hA);
    wr(12'h0F0, 0); wr(12'h0F4, 0);
    rd(12'h0F0, rv); check("R2 clear lo", rv, 0);
    rd(12'h0F4, rv); check("R2 clear hi", rv, 0);

    // R4 random one-shot delays
    for (int k = 0; k < 6; k++) begin
      doReset();
      d = int'($urandom_range(40, 1));
      wr(chA(0, 8), 32'(d)); wr(chA(0, 0), 32'h1); wr(12'h010, 32'h1);
      watch(d + 6, 0);
      check("R4 oneshot time", 64'(firstHit[0]), 64'(d + 1));
      check("R4 oneshot width", 64'(hitCnt[0]), 1);
    end

    // R4 zero compare
    doReset();
    wr(chA(1, 8), 0); wr(chA(1, 0), 32'h1); wr(12'h010, 32'h1);
    watch(5, 1);
    check("R4 zero compare", 64'(firstHit[1]), 1);

    // R4 interrupt enable clear
    doReset();
    wr(chA(2, 8), 3); wr(chA(2, 0), 32'h10); wr(12'h010, 32'h1);
    watch(12, 2);
    check("R4 ien off line", 64'(hitCnt[2]), 0);
    rd(12'h020, rv); check("R4 ien off status", rv, 0);

    // R5 R6 periodic
    doReset();
    wr(chA(0, 0), 32'h7); wr(chA(0, 8), 10);
    rd(chA(0, 0), rv); check("R5 value-set cleared", rv, 32'h103);
    wr(chA(0, 8), 7);
    rd(chA(0, 8), rv); check("R5 period write keeps compare", rv, 10);
    wr(12'h010, 32'h1);
    watch(26, 0);
    check("R6 pulse count", 64'(seqN), 3);
    check("R6 first", 64'(seq[0]), 11);
    check("R6 second", 64'(seq[1]), 18);
    check("R6 third", 64'(seq[2]), 25);

    // R7 level
    doReset();
    wr(chA(1, 0), 32'h11); wr(chA(1, 8), 4); wr(12'h010, 32'h1);
    watch(10, 1);
    check("R7 level first", 64'(firstHit[1]), 5);
    check("R7 level held", 64'(hitCnt[1]), 6);
    rd(12'h020, rv); check("R7 status set", rv, 32'h2);
    wr(12'h020, 32'h1);
    rd(12'h020, rv); check("R7 other bit no clear", rv, 32'h2);
    wr(12'h020, 32'h2);
    rd(12'h020, rv); check("R7 status cleared", rv, 0);
    check("R7 line low", 64'(irqLine[1]), 0);

    // R8 32-bit compare
    doReset();
    wr(12'h0F4, 5); wr(chA(0, 0), 32'h9); wr(chA(0, 8), 8); wr(12'h010, 32'h1);
    watch(12, 0);
    check("R8 low-word match", 64'(firstHit[0]), 9);
    check("R8 single match", 64'(hitCnt[0]), 1);

    doReset();
    wr(12'h0F0, 32'hFFFF_FFF0); wr(chA(0, 0), 32'hF);
    wr(chA(0, 8), 32'hFFFF_FFF8); wr(chA(0, 8), 32'h10); wr(12'h010, 32'h1);
    watch(26, 0);
    check("R8 wrap count", 64'(seqN), 2);
    check("R8 wrap first", 64'(seq[0]), 9);
    check("R8 wrap second", 64'(seq[1]), 25);
    wr(12'h010, 0);
    rd(chA(0, 8), rv); check("R8 compare wrapped", rv, 32'h18);
    rd(chA(0, 12), rv); check("R8 no carry", rv, 0);

    // R9 legacy replacement
    doReset();
    wr(chA(0, 8), 5); wr(chA(0, 0), 1); wr(chA(1, 8), 5); wr(chA(1, 0), 1);
    wr(12'h010, 32'h3);
    watch(10, 3);
    check("R9 timer line", 64'(firstHit[3]), 6);
    check("R9 rtc line", 64'(firstHit[4]), 6);
    check("R9 normal lines quiet", 64'(lineSeen), 0);
    rd(12'h010, rv); check("R9 gcfg", rv, 3);

    // R10 message delivery with collision
    doReset();
    wr(chA(1, 16), 32'hCAFE_0001); wr(chA(1, 20), 32'hFEE0_0010);
    wr(chA(2, 16), 32'h0BAD_0002); wr(chA(2, 20), 32'hFEE0_0020);
    wr(chA(1, 0), 32'h21); wr(chA(2, 0), 32'h21);
    wr(chA(1, 8), 6); wr(chA(2, 8), 6);
    rd(chA(2, 20), rv); check("R10 route addr readback", rv, 32'hFEE0_0020);
    wr(12'h010, 32'h1);
    watch(10, 5);
    check("R10 msg time", 64'(firstHit[5]), 7);
    check("R10 msg width", 64'(hitCnt[5]), 1);
    check("R10 msg data", capData, 32'hCAFE_0001);
    check("R10 msg addr", capAddr, 32'hFEE0_0010);
    check("R10 no wire", 64'(lineSeen), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule